// File: doc/BRIEF.md
# Jitter Smoothing Elastic Buffer

This block takes a serial bit stream whose bits arrive on an irregular, gapped or bursty write strobe and re-times it onto a steady output strobe. The write strobe is already synchronous to a fast system clock, so the block has a single clock domain. Incoming bits are stored in a circular bit buffer. An output strobe is produced by dividing the fast clock. At each output strobe one bit is read out. With a 24.704 MHz system clock the nominal divide of 16 gives a 1.544 MHz output bit rate.

The buffer can be 32 bits deep, for low delay, or 128 bits deep, for tolerance of large wander. The divider normally counts 16 system clocks per output bit. When the fill level comes close to full, it counts 15 so that the reader catches up. When the fill level comes close to empty, it counts 17. Each shortened or lengthened period sets a sticky status flag, which stays set until a clear pulse arrives. In the deep setting the guard band is 4 bits on each side, which tolerates 120 UI peak-to-peak. In the shallow setting it is 2 bits on each side, which tolerates 28 UI peak-to-peak.

A path-select input puts the buffer in either the receive stream or the transmit stream; the other stream passes straight through. A bypass input removes the buffer from both streams. Changing the depth or the bypass setting flushes the buffer and restarts it half full.

Top module: `jit_smoother`

## Requirements
- R1: While reset is asserted and after its release, trip_flag is 0. The first buffered output strobe appears on the 16th rising clock edge after reset is released, and not before.
- R2: While the fill level stays strictly inside the guard bands, every output strobe period is 16 clocks and trip_flag stays 0.
- R3: Bits leave the buffered path in arrival order. After a reset or a flush, the first depth/2 output bits are 0; output bit k (k >= depth/2) is input bit k - depth/2.
- R4: deep_sel = 1 selects a depth of 128 with a 4-bit guard band on each side. deep_sel = 0 selects a depth of 32 with a 2-bit guard band. An output strobe period starts as a 15-clock period when the fill level (write pointer minus read pointer, modulo the depth) is at least depth minus guard. It starts as a 17-clock period when the fill level is at most the guard.
- R5: When input arrives faster than the nominal rate, 15-clock output periods occur, and the fill level is held below the full depth without data loss.
- R6: When input arrives slower than the nominal rate, 17-clock output periods occur, and the fill level is held above empty without data loss.
- R7: trip_flag is set in the same cycle as the output strobe that starts a 15-clock or 17-clock period.
- R8: trip_flag stays 1 until a cycle with trip_clr = 1 and no new trip, after which it reads 0. If a clear and a new trip fall in the same cycle, the flag stays 1.
- R9: With bypass = 1, both output streams equal their input streams combinationally, and no trip occurs.
- R10: path_sel = 0 buffers the receive stream and passes the transmit stream through. path_sel = 1 buffers the transmit stream and passes the receive stream through.
- R11: A change of deep_sel or bypass flushes all stored bits to 0 and sets the fill level to half the new depth.
- R12: Every buffered output strobe period is 15, 16 or 17 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sel | input | 1 | 1: 128-bit depth, 0: 32-bit depth |
| bypass | input | 1 | 1: buffer removed from both streams |
| path_sel | input | 1 | 0: receive stream buffered, 1: transmit stream buffered |
| trip_clr | input | 1 | Clear pulse for trip_flag |
| rx_in_bit | input | 1 | Receive stream data in |
| rx_in_stb | input | 1 | Receive stream write strobe |
| tx_in_bit | input | 1 | Transmit stream data in |
| tx_in_stb | input | 1 | Transmit stream write strobe |
| rx_out_bit | output | 1 | Receive stream data out |
| rx_out_stb | output | 1 | Receive stream output strobe |
| tx_out_bit | output | 1 | Transmit stream data out |
| tx_out_stb | output | 1 | Transmit stream output strobe |
| trip_flag | output | 1 | Sticky limit-trip status |

## Verification
The output strobe and output bit of the buffered path come from a register loaded at the divider's terminal count. They therefore appear one edge after the read decision, and the first one appears on the 16th edge after reset is released. trip_flag is loaded on that same edge, so the bench checks the flag together with the strobe at the same falling edge. All outputs are sampled on or just after the falling clock edge. The output period is measured as the difference of edge counts between strobes, and data is compared by strobe index against the logged input bits, shifted by half the depth. Bypass and pass-through paths are combinational, so they are checked one time unit after the inputs are driven, before the next edge. The guard-band crossing points are checked by the strobe index of the first non-16 period, whose expected range follows from the rate mismatch and the half-depth start.

// File: rtl/jit_smoother_pkg.sv
package jit_smoother_pkg;

  // Which stream carries the elastic buffer
  typedef enum logic {
    PATH_RX = 1'b0,
    PATH_TX = 1'b1
  } path_e;

  // Kind of output period the divider starts
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;

endpackage

// File: rtl/jit_store.sv
module jit_store #(
  parameter int unsigned DEPTH_DEEP    = 128,
  parameter int unsigned DEPTH_SHALLOW = 32,
  parameter int unsigned PTR_W         = $clog2(DEPTH_DEEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             deep_sel,
  input  logic             bypass,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             rd_en,
  output logic             rd_bit,
  output logic             rd_vld,
  output logic [PTR_W-1:0] fill
);

  localparam logic [PTR_W-1:0] MASK_DEEP = PTR_W'(DEPTH_DEEP - 1);
  localparam logic [PTR_W-1:0] MASK_SH   = PTR_W'(DEPTH_SHALLOW - 1);
  localparam logic [PTR_W-1:0] HALF_DEEP = PTR_W'(DEPTH_DEEP / 2);
  localparam logic [PTR_W-1:0] HALF_SH   = PTR_W'(DEPTH_SHALLOW / 2);

  logic [DEPTH_DEEP-1:0] mem_q, mem_d;
  logic [PTR_W-1:0]      wp_q, wp_d, rp_q, rp_d;
  logic [PTR_W-1:0]      mask, half;
  logic                  deep_q, byp_q, pend_q;
  logic                  reinit;
  logic                  rd_bit_q, rd_bit_d, rd_vld_q, rd_vld_d;

  // Next-state logic
  always_comb begin
    mask     = deep_sel ? MASK_DEEP : MASK_SH;
    half     = deep_sel ? HALF_DEEP : HALF_SH;
    reinit   = pend_q | (deep_sel != deep_q) | (bypass != byp_q);
    mem_d    = mem_q;
    wp_d     = wp_q;
    rp_d     = rp_q;
    rd_bit_d = rd_bit_q;
    rd_vld_d = 1'b0;
    if (reinit) begin
      mem_d = '0;
      wp_d  = half;
      rp_d  = '0;
    end else begin
      if (wr_en) begin
        mem_d[wp_q & mask] = wr_bit;
        wp_d               = (wp_q + 1'b1) & mask;
      end
      if (rd_en) begin
        rd_bit_d = mem_q[rp_q & mask];
        rd_vld_d = 1'b1;
        rp_d     = (rp_q + 1'b1) & mask;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q    <= '0;
      wp_q     <= '0;
      rp_q     <= '0;
      deep_q   <= 1'b0;
      byp_q    <= 1'b0;
      pend_q   <= 1'b1;
      rd_bit_q <= 1'b0;
      rd_vld_q <= 1'b0;
    end else begin
      mem_q    <= mem_d;
      wp_q     <= wp_d;
      rp_q     <= rp_d;
      deep_q   <= deep_sel;
      byp_q    <= bypass;
      pend_q   <= 1'b0;
      rd_bit_q <= rd_bit_d;
      rd_vld_q <= rd_vld_d;
    end
  end

  assign fill   = (wp_q - rp_q) & mask;
  assign rd_bit = rd_bit_q;
  assign rd_vld = rd_vld_q;

  // R11: a flush leaves the buffer exactly half full
  assert_flush_half_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reinit ##1 !reinit) |-> (fill == half))
    else $error("flush did not restart at half depth");

  // R3: no read is reported in the cycle after a flush edge
  assert_no_read_on_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reinit && rd_en) |=> !rd_vld)
    else $error("read reported across a flush");

endmodule

// File: rtl/jit_divider.sv
module jit_divider import jit_smoother_pkg::*; #(
  parameter int unsigned DEPTH_DEEP     = 128,
  parameter int unsigned DEPTH_SHALLOW  = 32,
  parameter int unsigned MARGIN_DEEP    = 4,
  parameter int unsigned MARGIN_SHALLOW = 2,
  parameter int unsigned DIV_NOM        = 16,
  parameter int unsigned PTR_W          = $clog2(DEPTH_DEEP),
  parameter int unsigned CNT_W          = $clog2(DIV_NOM + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             deep_sel,
  input  logic [PTR_W-1:0] fill,
  input  logic             trip_clr,
  output logic             tick,
  output logic             trip
);

  localparam logic [CNT_W-1:0] LEN_NOM  = CNT_W'(DIV_NOM);
  localparam logic [CNT_W-1:0] LEN_FAST = CNT_W'(DIV_NOM - 1);
  localparam logic [CNT_W-1:0] LEN_SLOW = CNT_W'(DIV_NOM + 1);
  localparam logic [PTR_W-1:0] HI_DEEP  = PTR_W'(DEPTH_DEEP - MARGIN_DEEP);
  localparam logic [PTR_W-1:0] HI_SH    = PTR_W'(DEPTH_SHALLOW - MARGIN_SHALLOW);
  localparam logic [PTR_W-1:0] LO_DEEP  = PTR_W'(MARGIN_DEEP);
  localparam logic [PTR_W-1:0] LO_SH    = PTR_W'(MARGIN_SHALLOW);

  logic [CNT_W-1:0] cnt_q, cnt_d, len_q, len_d, len_pick;
  logic [PTR_W-1:0] hi, lo;
  logic             near_full, near_empty;
  logic             trip_q, trip_d;
  adj_e             adj;

  // Next-state logic
  always_comb begin
    hi         = deep_sel ? HI_DEEP : HI_SH;
    lo         = deep_sel ? LO_DEEP : LO_SH;
    near_full  = (fill >= hi);
    near_empty = (fill <= lo);
    if (near_full)       adj = ADJ_SHORT;
    else if (near_empty) adj = ADJ_LONG;
    else                 adj = ADJ_NONE;
    case (adj)
      ADJ_SHORT: len_pick = LEN_FAST;
      ADJ_LONG:  len_pick = LEN_SLOW;
      default:   len_pick = LEN_NOM;
    endcase
    tick   = (cnt_q == len_q - 1'b1);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    len_d  = tick ? len_pick : len_q;
    trip_d = (trip_q & ~trip_clr) | (tick & (adj != ADJ_NONE));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= LEN_NOM;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      trip_q <= trip_d;
    end
  end

  assign trip = trip_q;

  // R12: only the three legal period lengths are ever in use
  assert_len_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == LEN_FAST) || (len_q == LEN_NOM) || (len_q == LEN_SLOW))
    else $error("illegal period length");

  // R12: the count stays inside the current period
  assert_cnt_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q)
    else $error("period counter overran");

  // R2: a terminal count inside the bands starts a nominal period
  assert_nominal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !near_full && !near_empty) |=> (len_q == LEN_NOM))
    else $error("nominal period not taken");

  // R7: a near-full terminal count raises the flag
  assert_trip_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && near_full) |=> trip_q)
    else $error("trip not raised near full");

  // R7: a near-empty terminal count raises the flag
  assert_trip_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && near_empty) |=> trip_q)
    else $error("trip not raised near empty");

  // R8: the flag holds without a clear
  assert_trip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !trip_clr) |=> trip_q)
    else $error("trip flag dropped without clear");

endmodule

// File: rtl/jit_smoother.sv
module jit_smoother import jit_smoother_pkg::*; #(
  parameter int unsigned DEPTH_DEEP     = 128,
  parameter int unsigned DEPTH_SHALLOW  = 32,
  parameter int unsigned MARGIN_DEEP    = 4,
  parameter int unsigned MARGIN_SHALLOW = 2,
  parameter int unsigned DIV_NOM        = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_sel,
  input  logic bypass,
  input  logic path_sel,
  input  logic trip_clr,
  input  logic rx_in_bit,
  input  logic rx_in_stb,
  input  logic tx_in_bit,
  input  logic tx_in_stb,
  output logic rx_out_bit,
  output logic rx_out_stb,
  output logic tx_out_bit,
  output logic tx_out_stb,
  output logic trip_flag
);

  localparam int unsigned PTR_W = $clog2(DEPTH_DEEP);
  localparam int unsigned CNT_W = $clog2(DIV_NOM + 2);

  logic             use_tx;
  logic             sel_bit, sel_stb;
  logic             wr_en, rd_en, tick;
  logic             buf_bit, buf_vld;
  logic             rx_thru, tx_thru;
  logic [PTR_W-1:0] fill;

  always_comb begin
    use_tx  = (path_e'(path_sel) == PATH_TX);
    sel_bit = use_tx ? tx_in_bit : rx_in_bit;
    sel_stb = use_tx ? tx_in_stb : rx_in_stb;
    wr_en   = sel_stb & ~bypass;
    rd_en   = tick & ~bypass;
    rx_thru = bypass | use_tx;
    tx_thru = bypass | ~use_tx;
    rx_out_bit = rx_thru ? rx_in_bit : buf_bit;
    rx_out_stb = rx_thru ? rx_in_stb : buf_vld;
    tx_out_bit = tx_thru ? tx_in_bit : buf_bit;
    tx_out_stb = tx_thru ? tx_in_stb : buf_vld;
  end

  jit_store #(
    .DEPTH_DEEP   (DEPTH_DEEP),
    .DEPTH_SHALLOW(DEPTH_SHALLOW),
    .PTR_W        (PTR_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .deep_sel(deep_sel),
    .bypass  (bypass),
    .wr_en   (wr_en),
    .wr_bit  (sel_bit),
    .rd_en   (rd_en),
    .rd_bit  (buf_bit),
    .rd_vld  (buf_vld),
    .fill    (fill)
  );

  jit_divider #(
    .DEPTH_DEEP    (DEPTH_DEEP),
    .DEPTH_SHALLOW (DEPTH_SHALLOW),
    .MARGIN_DEEP   (MARGIN_DEEP),
    .MARGIN_SHALLOW(MARGIN_SHALLOW),
    .DIV_NOM       (DIV_NOM),
    .PTR_W         (PTR_W),
    .CNT_W         (CNT_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .deep_sel(deep_sel),
    .fill    (fill),
    .trip_clr(trip_clr),
    .tick    (tick),
    .trip    (trip_flag)
  );

  // R9: bypass routes both streams straight through
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (rx_out_stb == rx_in_stb) && (tx_out_stb == tx_in_stb) &&
               (rx_out_bit == rx_in_bit) && (tx_out_bit == tx_in_bit))
    else $error("bypass not transparent");

  // R10: the unbuffered stream is passed through
  assert_thru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (path_sel && !bypass) |-> (rx_out_stb == rx_in_stb))
    else $error("receive stream not passed through");

endmodule

// File: tb/test_jit_smoother.sv
module test_jit_smoother;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic deep_sel = 1'b0, bypass = 1'b0, path_sel = 1'b0, trip_clr = 1'b0;
  logic rx_in_bit = 1'b0, rx_in_stb = 1'b0, tx_in_bit = 1'b0, tx_in_stb = 1'b0;
  logic rx_out_bit, rx_out_stb, tx_out_bit, tx_out_stb, trip_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  jit_smoother i_jit_smoother (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .bypass(bypass),
    .path_sel(path_sel), .trip_clr(trip_clr),
    .rx_in_bit(rx_in_bit), .rx_in_stb(rx_in_stb),
    .tx_in_bit(tx_in_bit), .tx_in_stb(tx_in_stb),
    .rx_out_bit(rx_out_bit), .rx_out_stb(rx_out_stb),
    .tx_out_bit(tx_out_bit), .tx_out_stb(tx_out_stb),
    .trip_flag(trip_flag)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;

  // stimulus generator state
  bit gen_on = 1'b0, gen_tx = 1'b0;
  int gen_per = 16, gen_cnt = 0, sent_n = 0;
  bit sent [0:8191];
  logic [15:0] lfsr = 16'hACE1;
  logic gb;

  // monitor state
  bit mon_on = 1'b0, have_last = 1'b0;
  int rcv_n = 0, half = 16, last_cyc = 0, g15 = 0, g16 = 0, g17 = 0, first_adj = -1;
  logic mon_stb, mon_bit;
  assign mon_stb = gen_tx ? tx_out_stb : rx_out_stb;
  assign mon_bit = gen_tx ? tx_out_bit : rx_out_bit;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Input strobe every gen_per clocks, pseudo-random data
  always @(negedge clk) begin
    if (gen_on) begin
      if (gen_cnt >= gen_per - 1) begin
        gen_cnt = 0;
        gb = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (gen_tx) begin tx_in_bit = gb; tx_in_stb = 1'b1; end
        else        begin rx_in_bit = gb; rx_in_stb = 1'b1; end
        if (sent_n < 8192) sent[sent_n] = gb;
        sent_n++;
      end else begin
        gen_cnt++;
        rx_in_stb = 1'b0;
        tx_in_stb = 1'b0;
      end
    end else begin
      rx_in_stb = 1'b0;
      tx_in_stb = 1'b0;
    end
  end

  // Buffered-path monitor: data order (R3) and period (R12)
  always @(negedge clk) begin
    if (mon_on && mon_stb === 1'b1) begin
      int gap;
      logic exp_b;
      if (rcv_n < half) exp_b = 1'b0;
      else if (rcv_n - half < 8192) exp_b = sent[rcv_n - half];
      else exp_b = 1'b0;
      chk(mon_bit === exp_b, "R3 output bit order", int'(mon_bit), int'(exp_b));
      if (have_last) begin
        gap = cyc - last_cyc;
        chk(gap >= 15 && gap <= 17, "R12 output period", gap, 16);
        if (gap == 15) g15++;
        else if (gap == 16) g16++;
        else if (gap == 17) g17++;
        if (gap != 16 && first_adj < 0) first_adj = rcv_n;
      end
      have_last = 1'b1;
      last_cyc = cyc;
      rcv_n++;
    end
  end

  task automatic start_case(input bit deep, input bit tx, input int per);
    gen_on = 1'b0; mon_on = 1'b0; rst_n = 1'b0;
    deep_sel = deep; path_sel = tx; bypass = 1'b0; trip_clr = 1'b0;
    gen_tx = tx; gen_per = per;
    sent_n = 0; rcv_n = 0; have_last = 1'b0;
    g15 = 0; g16 = 0; g17 = 0; first_adj = -1;
    half = deep ? 64 : 16;
    rx_in_bit = 1'b0; tx_in_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk(trip_flag == 1'b0, "R1 trip flag in reset", int'(trip_flag), 0);
    chk(mon_stb == 1'b0, "R1 output strobe in reset", int'(mon_stb), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      #1;
      if (i == 1) begin gen_cnt = per - 1; gen_on = 1'b1; end
      chk(mon_stb == (i == 16), "R1 first output strobe timing", int'(mon_stb), int'(i == 16));
      chk(trip_flag == 1'b0, "R1 trip flag after reset", int'(trip_flag), 0);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seen;

    // Nominal rate, shallow
    start_case(1'b0, 1'b0, 16);
    run(2000);
    chk(trip_flag == 1'b0, "R2 no trip at nominal rate", int'(trip_flag), 0);
    chk(g15 == 0 && g17 == 0, "R2 only 16-clock periods", g15 + g17, 0);
    chk(g16 > 100, "R2 periods observed", g16, 101);
    chk(rcv_n > half + 50, "R3 enough data compared", rcv_n, half + 51);

    // Fast input, shallow
    start_case(1'b0, 1'b0, 15);
    run(6000);
    chk(trip_flag == 1'b1, "R7 trip after short periods", int'(trip_flag), 1);
    chk(g15 > 0, "R5 short periods used", g15, 1);
    chk(g17 == 0, "R5 no long periods", g17, 0);
    chk(first_adj >= 150 && first_adj <= 300, "R4 shallow near-full point", first_adj, 225);

    // Hold clear while trips recur: flag only with a fresh trip strobe
    @(negedge clk); #1 trip_clr = 1'b1;
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #2;
      if (trip_flag) begin
        seen++;
        chk(mon_stb == 1'b1, "R8 flag only with new trip under clear", int'(mon_stb), 1);
      end
    end
    trip_clr = 1'b0;
    chk(seen > 0, "R8 set wins over clear", seen, 1);

    // Bypass: no trips, clear works, pass-through
    gen_on = 1'b0; mon_on = 1'b0;
    @(negedge clk); #1 bypass = 1'b1;
    run(3);
    #1 trip_clr = 1'b1;
    @(negedge clk); #1 trip_clr = 1'b0;
    chk(trip_flag == 1'b0, "R8 flag cleared", int'(trip_flag), 0);
    run(60);
    chk(trip_flag == 1'b0, "R9 no trip in bypass", int'(trip_flag), 0);
    for (int ps = 0; ps < 2; ps++) begin
      path_sel = ps[0];
      for (int v = 0; v < 16; v++) begin
        @(negedge clk); #1;
        rx_in_bit = v[0]; rx_in_stb = v[1]; tx_in_bit = v[2]; tx_in_stb = v[3];
        #1;
        chk(rx_out_bit == v[0] && rx_out_stb == v[1], "R9 receive follows input",
            int'({rx_out_stb, rx_out_bit}), v & 3);
        chk(tx_out_bit == v[2] && tx_out_stb == v[3], "R9 transmit follows input",
            int'({tx_out_stb, tx_out_bit}), (v >> 2) & 3);
      end
    end

    // Slow input, shallow
    start_case(1'b0, 1'b0, 17);
    run(6000);
    chk(trip_flag == 1'b1, "R7 trip after long periods", int'(trip_flag), 1);
    chk(g17 > 0, "R6 long periods used", g17, 1);
    chk(g15 == 0, "R6 no short periods", g15, 0);
    chk(first_adj >= 150 && first_adj <= 330, "R4 shallow near-empty point", first_adj, 238);

    // Fast input, deep
    start_case(1'b1, 1'b0, 15);
    run(18000);
    chk(g15 > 0, "R5 deep short periods used", g15, 1);
    chk(first_adj >= 800 && first_adj <= 1000, "R4 deep near-full point", first_adj, 900);
    chk(trip_flag == 1'b1, "R7 deep trip", int'(trip_flag), 1);

    // Slow input, deep
    start_case(1'b1, 1'b0, 17);
    run(20000);
    chk(g17 > 0, "R6 deep long periods used", g17, 1);
    chk(g15 == 0, "R6 deep no short periods", g15, 0);
    chk(first_adj >= 900 && first_adj <= 1150, "R4 deep near-empty point", first_adj, 1020);

    // Transmit path buffered, receive passes through
    start_case(1'b0, 1'b1, 16);
    run(1500);
    chk(g15 == 0 && g17 == 0 && g16 > 50, "R10 transmit buffered at nominal", g16, 90);
    chk(trip_flag == 1'b0, "R10 no trip on transmit path", int'(trip_flag), 0);
    @(negedge clk); #1 rx_in_bit = 1'b1; rx_in_stb = 1'b1;
    #1;
    chk(rx_out_bit == 1'b1 && rx_out_stb == 1'b1, "R10 receive passes through",
        int'({rx_out_stb, rx_out_bit}), 3);

    // Depth change mid-stream flushes
    start_case(1'b1, 1'b0, 16);
    run(3000);
    do begin @(negedge clk); #1; end while (mon_stb !== 1'b1);
    gen_on = 1'b0;
    deep_sel = 1'b0;
    half = 16; rcv_n = 0; sent_n = 0; have_last = 1'b0;
    g15 = 0; g16 = 0; g17 = 0;
    @(negedge clk); #1;
    gen_cnt = 15; gen_on = 1'b1;
    run(1500);
    chk(rcv_n > half + 30, "R11 data after flush compared", rcv_n, half + 31);
    chk(g15 == 0 && g17 == 0, "R11 restart at half depth", g15 + g17, 0);
    chk(trip_flag == 1'b0, "R11 no trip after flush", int'(trip_flag), 0);

    gen_on = 1'b0; mon_on = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule